// File: doc/BRIEF.md
# Free-running timer with input capture and output compare

The block keeps a 16-bit up counter that never stops. It advances once every count period, and a prescaler sets that period to 2, 8 or 32 machine-clock cycles. The same time base serves two kinds of channels. Each input capture channel synchronizes a pin, watches it for a chosen kind of edge, and stores the counter value when that edge arrives. Each output compare channel holds a compare value and toggles its own output pin at the moment the counter counts up to that value.

Software reaches every setting through one word-wide register port. A write takes effect on the clock edge that samples it. Reads are combinational from the address. Event flags (counter wrap, each capture, each compare) stay set until software writes a 1 to the matching bit. Each flag also drives an interrupt output directly.

Top module: `frt_capcmp_timer`

## Requirements
- R1: The counter at address 0x0 is 16 bits wide. It increases by exactly one at the end of each count period and never changes in any other way, except when software writes it or clears it.
- R2: Bits [1:0] of the control register at address 0x1 set the count period. Code 0 gives 2 clocks, code 1 gives 8 clocks, and codes 2 and 3 give 32 clocks. After the counter is loaded, its first increment comes one full period later.
- R3: When the counter steps from 0xFFFF to 0x0000, bit 0 of the flag register at address 0x4 and irq_ovf_o go high. Writing 1 to that bit clears it.
- R4: A write to address 0x0 loads the counter on that same clock edge and restarts the prescaler phase.
- R5: Writing 1 to bit 2 of the control register sets the counter to zero and restarts the prescaler phase. This bit always reads back as 0.
- R6: Each capture pin passes through a two-flop synchronizer. On the third clock edge after a pin change, capture register c (at address 0x5+c) takes the counter value from the cycle before that edge.
- R7: The edge-select register at address 0x2 holds a 2-bit code at bits [2c+1:2c] for each capture channel c. Code 0 means no capture, 1 means rising edge, 2 means falling edge and 3 means either edge. An edge that the code excludes leaves the capture register and the flag untouched.
- R8: Each capture sets bit 1+c of the flag register and irq_cap_o[c]. The bit stays set across later events until software writes 1 to it.
- R9: Compare register c is at address 0x8+c. On the clock edge where the counter counts up to that value, cmp_pin_o[c] toggles and bit 3+c of the flag register (and irq_cmp_o[c]) goes high.
- R10: Bit c of the compare-enable register at address 0x3 gates both the pin toggle and the flag for channel c. When the bit is 0, a match has no effect.
- R11: Writing a compare register with the value the counter already holds causes no match until the counter counts up to that value again.
- R12: If a new event sets a flag on the same edge that software clears it, the flag stays set.
- R13: Reset (active high, synchronous) sets the counter, the prescaler, all flags, all pins and all configuration registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| cap_pin_i | input | 2 | Capture input pins, asynchronous |
| cmp_pin_o | output | 4 | Compare output pins |
| irq_ovf_o | output | 1 | Counter wrap request |
| irq_cap_o | output | 2 | Capture requests, one per channel |
| irq_cmp_o | output | 4 | Compare requests, one per channel |

## Verification
A compare match can set its flag on the same edge that a software write-one-to-clear targets that flag. The bench forces this collision: it loads the counter three counts below the compare value at the fastest period, then times the flag-clear write to land exactly six clocks after the load. After the collision the flag must still read 1, and a later clear on its own must drop it. The same set-wins rule applies to the wrap and capture flags, and the table-driven wrap vectors show the wrap flag coming up on the counter's rollover edge.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int ADDR_W = 4;
    localparam int DIV_W  = 6;

    // Register addresses; per-channel banks start at the base and step by one
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'h0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h1;
    localparam logic [ADDR_W-1:0] A_CAPCFG = 4'h2;
    localparam logic [ADDR_W-1:0] A_CMPEN  = 4'h3;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CAP0   = 4'h5;
    localparam logic [ADDR_W-1:0] A_CMP0   = 4'h8;

    localparam int CTRL_CLR_BIT = 2;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef enum logic [1:0] {
        DIV_BY2  = 2'd0,
        DIV_BY8  = 2'd1,
        DIV_BY32 = 2'd2,
        DIV_ALT  = 2'd3
    } div_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Terminal value of the prescaler phase counter for a period code
    function automatic logic [DIV_W-1:0] div_limit(input div_sel_e s);
        case (s)
            DIV_BY2: return DIV_W'(1);
            DIV_BY8: return DIV_W'(7);
            default: return DIV_W'(31);
        endcase
    endfunction

    function automatic logic edge_hit(input edge_sel_e s, input edge_t e);
        case (s)
            EDGE_RISE: return e.rise;
            EDGE_FALL: return e.fall;
            EDGE_BOTH: return e.rise | e.fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/frt_timebase.sv
module frt_timebase
    import frt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  div_sel_e         sel_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tick_o,
    output logic             wrap_o
);
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim    = div_limit(sel_i);
    assign tick_o = !load_i && (div_q >= lim);
    assign wrap_o = tick_o && (cnt_q == '1);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            div_q <= '0;
            cnt_q <= load_val_i;
        end else if (tick_o) begin
            div_q <= '0;
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // R1: without a load the counter holds or steps by one
    p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(load_i) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R2: prescaler phase never passes the selected terminal value
    p_div_bound_r2: assert property (@(posedge clk) disable iff (rst)
        $stable(sel_i) |-> div_q <= lim);

    // R4: a load lands on the next edge with a fresh prescaler phase
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i) && div_q == '0));

endmodule

// File: rtl/frt_capture.sv
module frt_capture
    import frt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  edge_sel_e        sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             evt_o,
    output logic [CNT_W-1:0] cap_o
);
    logic  sync1_q, sync2_q, prev_q;
    edge_t edges;
    logic [CNT_W-1:0] cap_q;

    assign edges.rise = sync2_q & ~prev_q;
    assign edges.fall = ~sync2_q & prev_q;
    assign evt_o      = edge_hit(sel_i, edges);
    assign cap_o      = cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
            cap_q   <= '0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
            if (evt_o) cap_q <= cnt_i;
        end
    end

    // R7: capture register moves only on a selected edge
    p_cap_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(evt_o) |-> $stable(cap_q));

    // R6: the stored value is the counter of the detection cycle
    p_cap_value_r6: assert property (@(posedge clk) disable iff (rst)
        evt_o |=> cap_q == $past(cnt_i));

endmodule

// File: rtl/frt_compare.sv
module frt_compare
    import frt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             hit_o,
    output logic             pin_o
);
    logic pin_q;

    // A match is the counter stepping into the compare value
    assign hit_o = en_i && tick_i && ((cnt_i + CNT_W'(1)) == cmp_i);
    assign pin_o = pin_q;

    always_ff @(posedge clk) begin
        if (rst)        pin_q <= 1'b0;
        else if (hit_o) pin_q <= ~pin_q;
    end

    // R10: the pin moves only after an enabled counting step
    p_pin_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (pin_q != $past(pin_q)) |-> ($past(en_i) && $past(tick_i)));

endmodule

// File: rtl/frt_capcmp_timer.sv
module frt_capcmp_timer
    import frt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CAP = 2,
    parameter int N_CMP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [N_CAP-1:0]  cap_pin_i,
    output logic [N_CMP-1:0]  cmp_pin_o,
    output logic              irq_ovf_o,
    output logic [N_CAP-1:0]  irq_cap_o,
    output logic [N_CMP-1:0]  irq_cmp_o
);
    localparam int CAPF_LO = 1;
    localparam int CMPF_LO = 1 + N_CAP;
    localparam int FLAG_W  = 1 + N_CAP + N_CMP;

    div_sel_e         sel_q;
    edge_sel_e        capcfg_q [N_CAP];
    logic [N_CMP-1:0] cmpen_q;
    logic [CNT_W-1:0] cmp_q [N_CMP];
    logic             ovf_q;
    logic [N_CAP-1:0] capf_q;
    logic [N_CMP-1:0] cmpf_q;

    logic [CNT_W-1:0] cnt;
    logic             tick, wrap;
    logic             wr_count, wr_ctrl, wr_flags, load;
    logic [CNT_W-1:0] load_val;
    logic [N_CAP-1:0] cap_evt;
    logic [CNT_W-1:0] cap_val [N_CAP];
    logic [N_CMP-1:0] cmp_evt;

    assign wr_count = bus_wr && (bus_addr == A_COUNT);
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_flags = bus_wr && (bus_addr == A_FLAGS);
    assign load     = wr_count || (wr_ctrl && bus_wdata[CTRL_CLR_BIT]);
    assign load_val = wr_count ? bus_wdata : '0;

    frt_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .sel_i      (sel_q),
        .load_i     (load),
        .load_val_i (load_val),
        .cnt_o      (cnt),
        .tick_o     (tick),
        .wrap_o     (wrap)
    );

    for (genvar c = 0; c < N_CAP; c++) begin : g_cap
        frt_capture #(.CNT_W(CNT_W)) u_cap (
            .clk   (clk),
            .rst   (rst),
            .pin_i (cap_pin_i[c]),
            .sel_i (capcfg_q[c]),
            .cnt_i (cnt),
            .evt_o (cap_evt[c]),
            .cap_o (cap_val[c])
        );

        // R8: a capture event always leaves its flag set
        p_capflag_r8: assert property (@(posedge clk) disable iff (rst)
            cap_evt[c] |=> capf_q[c]);
    end

    for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
        frt_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk    (clk),
            .rst    (rst),
            .cmp_i  (cmp_q[c]),
            .en_i   (cmpen_q[c]),
            .tick_i (tick),
            .cnt_i  (cnt),
            .hit_o  (cmp_evt[c]),
            .pin_o  (cmp_pin_o[c])
        );

        // R9, R12: a match sets its flag even against a clearing write
        p_cmpflag_r9: assert property (@(posedge clk) disable iff (rst)
            cmp_evt[c] |=> cmpf_q[c]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= DIV_BY2;
            cmpen_q <= '0;
            ovf_q   <= 1'b0;
            capf_q  <= '0;
            cmpf_q  <= '0;
            for (int c = 0; c < N_CAP; c++) capcfg_q[c] <= EDGE_OFF;
            for (int c = 0; c < N_CMP; c++) cmp_q[c] <= '0;
        end else begin
            if (wr_ctrl) sel_q <= div_sel_e'(bus_wdata[1:0]);
            if (bus_wr && bus_addr == A_CAPCFG) begin
                for (int c = 0; c < N_CAP; c++)
                    capcfg_q[c] <= edge_sel_e'(bus_wdata[2*c +: 2]);
            end
            if (bus_wr && bus_addr == A_CMPEN) cmpen_q <= bus_wdata[N_CMP-1:0];
            for (int c = 0; c < N_CMP; c++) begin
                if (bus_wr && bus_addr == (A_CMP0 + ADDR_W'(c))) cmp_q[c] <= bus_wdata;
            end
            // set has priority over a write-one-to-clear on the same edge
            ovf_q  <= (ovf_q & ~(wr_flags & bus_wdata[0])) | wrap;
            capf_q <= (capf_q & ~(wr_flags ? bus_wdata[CAPF_LO +: N_CAP] : '0)) | cap_evt;
            cmpf_q <= (cmpf_q & ~(wr_flags ? bus_wdata[CMPF_LO +: N_CMP] : '0)) | cmp_evt;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_COUNT:  bus_rdata = cnt;
            A_CTRL:   bus_rdata[1:0] = sel_q;
            A_CAPCFG: for (int c = 0; c < N_CAP; c++) bus_rdata[2*c +: 2] = capcfg_q[c];
            A_CMPEN:  bus_rdata[N_CMP-1:0] = cmpen_q;
            A_FLAGS:  bus_rdata[FLAG_W-1:0] = {cmpf_q, capf_q, ovf_q};
            default:  ;
        endcase
        for (int c = 0; c < N_CAP; c++)
            if (bus_addr == (A_CAP0 + ADDR_W'(c))) bus_rdata = cap_val[c];
        for (int c = 0; c < N_CMP; c++)
            if (bus_addr == (A_CMP0 + ADDR_W'(c))) bus_rdata = cmp_q[c];
    end

    assign irq_ovf_o = ovf_q;
    assign irq_cap_o = capf_q;
    assign irq_cmp_o = cmpf_q;

    // R3: the wrap flag follows a rollover, and the counter reads zero then
    p_ovf_flag_r3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (ovf_q && cnt == '0));

endmodule

// File: tb/frt_capcmp_timer_tb.sv
`timescale 1ns/1ps
module frt_capcmp_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  cap_pin_i = '0;
    logic [3:0]  cmp_pin_o;
    logic        irq_ovf_o;
    logic [1:0]  irq_cap_o;
    logic [3:0]  irq_cmp_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frt_capcmp_timer u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin_i(cap_pin_i),
        .cmp_pin_o(cmp_pin_o), .irq_ovf_o(irq_ovf_o), .irq_cap_o(irq_cap_o),
        .irq_cmp_o(irq_cmp_o)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] start;
        logic [7:0]  wait_n;
        logic [15:0] exp_cnt;
        logic        exp_ovf;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h1000, 8'd10,  16'h1005, 1'b0},
        '{2'd1, 16'h0100, 8'd20,  16'h0102, 1'b0},
        '{2'd2, 16'h0010, 8'd100, 16'h0013, 1'b0},
        '{2'd0, 16'hFFFE, 8'd5,   16'h0000, 1'b1},
        '{2'd2, 16'hFFFF, 8'd31,  16'hFFFF, 1'b0},
        '{2'd2, 16'hFFFF, 8'd32,  16'h0000, 1'b1},
        '{2'd1, 16'hFFFF, 8'd8,   16'h0000, 1'b1},
        '{2'd3, 16'h0200, 8'd64,  16'h0202, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge; returns at the following negedge
    task automatic bw(input logic [3:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        idle(3);
        // R13: reset state
        br(4'h0, rd); chk("R13 counter", rd, 16'h0000);
        br(4'h4, rd); chk("R13 flags", rd, 16'h0000);
        chk("R13 pins", {12'h0, cmp_pin_o}, 16'h0000);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2 R3 R4: table of period codes, start values and wraps
        for (int v = 0; v < NV; v++) begin
            bw(4'h4, 16'hFFFF);
            bw(4'h1, {14'h0, VECS[v].sel});
            bw(4'h0, VECS[v].start);
            idle(int'(VECS[v].wait_n));
            br(4'h0, rd); chk("R1/R2/R4 counter", rd, VECS[v].exp_cnt);
            br(4'h4, rd); chk("R3 wrap flag", {15'h0, rd[0]}, {15'h0, VECS[v].exp_ovf});
            chk("R3 irq_ovf", {15'h0, irq_ovf_o}, {15'h0, VECS[v].exp_ovf});
        end
        bw(4'h4, 16'h0001);
        br(4'h4, rd); chk("R3 wrap flag cleared", {15'h0, rd[0]}, 16'h0000);

        // R5: clear bit
        bw(4'h0, 16'h1234);
        bw(4'h1, 16'h0004);
        idle(3);
        br(4'h0, rd); chk("R5 counter after clear", rd, 16'h0001);
        br(4'h1, rd); chk("R5 clear bit reads 0", rd, 16'h0000);

        // R6 R7 R8: capture, ch0 rising, ch1 falling, slowest period
        bw(4'h1, 16'h0002);
        bw(4'h2, 16'h0009);
        bw(4'h4, 16'hFFFF);
        bw(4'h0, 16'h0500);
        cap_pin_i = 2'b11;
        idle(6);
        br(4'h5, rd); chk("R6 cap0 on rise", rd, 16'h0500);
        br(4'h6, rd); chk("R7 cap1 ignores rise", rd, 16'h0000);
        chk("R8 irq_cap after rise", {14'h0, irq_cap_o}, 16'h0001);
        bw(4'h0, 16'h0700);
        cap_pin_i = 2'b00;
        idle(6);
        br(4'h6, rd); chk("R7 cap1 on fall", rd, 16'h0700);
        br(4'h5, rd); chk("R7 cap0 ignores fall", rd, 16'h0500);
        br(4'h4, rd); chk("R8 both capture flags held", {14'h0, rd[2:1]}, 16'h0003);
        bw(4'h4, 16'h0002);
        br(4'h4, rd); chk("R8 clear one capture flag", {14'h0, rd[2:1]}, 16'h0002);
        // ch0 either edge, ch1 disabled
        bw(4'h2, 16'h0003);
        bw(4'h4, 16'hFFFF);
        bw(4'h0, 16'h0900);
        cap_pin_i = 2'b11;
        idle(6);
        br(4'h5, rd); chk("R7 cap0 both-edge rise", rd, 16'h0900);
        br(4'h6, rd); chk("R7 cap1 disabled", rd, 16'h0700);
        chk("R8 irq_cap disabled ch", {14'h0, irq_cap_o}, 16'h0001);
        bw(4'h0, 16'h0A00);
        cap_pin_i = 2'b10;
        idle(6);
        br(4'h5, rd); chk("R7 cap0 both-edge fall", rd, 16'h0A00);
        // R6: capture later in a count period
        bw(4'h0, 16'h0B00);
        idle(40);
        cap_pin_i = 2'b11;
        idle(6);
        br(4'h5, rd); chk("R6 cap0 after one step", rd, 16'h0B01);

        // R9 R10: compare ch0 enabled, ch1 disabled, same value
        bw(4'h1, 16'h0000);
        bw(4'h3, 16'h0001);
        bw(4'h8, 16'h2003);
        bw(4'h9, 16'h2003);
        bw(4'h4, 16'hFFFF);
        bw(4'h0, 16'h2000);
        idle(5);
        chk("R9 pins before match", {12'h0, cmp_pin_o}, 16'h0000);
        idle(1);
        chk("R9 pin0 toggles at match", {12'h0, cmp_pin_o}, 16'h0001);
        chk("R9 irq_cmp", {12'h0, irq_cmp_o}, 16'h0001);
        br(4'h4, rd); chk("R10 disabled ch1 no flag", {12'h0, rd[6:3]}, 16'h0001);
        bw(4'h0, 16'h2000);
        idle(6);
        chk("R9 pin0 toggles back", {12'h0, cmp_pin_o}, 16'h0000);

        // R11: compare written equal to the current count
        bw(4'h1, 16'h0002);
        bw(4'h3, 16'h0004);
        bw(4'h4, 16'hFFFF);
        bw(4'h0, 16'h3000);
        bw(4'hA, 16'h3000);
        idle(60);
        chk("R11 no match on equal write", {12'h0, cmp_pin_o}, 16'h0000);
        br(4'h4, rd); chk("R11 no flag on equal write", {12'h0, rd[6:3]}, 16'h0000);
        bw(4'h0, 16'h2FFF);
        idle(31);
        chk("R11 before counted match", {12'h0, cmp_pin_o}, 16'h0000);
        idle(1);
        chk("R11 counted match", {12'h0, cmp_pin_o}, 16'h0004);

        // R12: match and flag clear on the same edge
        bw(4'h1, 16'h0000);
        bw(4'h3, 16'h0008);
        bw(4'hB, 16'h4003);
        bw(4'h4, 16'hFFFF);
        bw(4'h0, 16'h4000);
        idle(5);
        bw(4'h4, 16'h0040);
        br(4'h4, rd); chk("R12 set beats clear", {15'h0, rd[6]}, 16'h0001);
        bw(4'h4, 16'h0040);
        br(4'h4, rd); chk("R12 later clear", {15'h0, rd[6]}, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule